// File: doc/BRIEF.md
# Prioritized CPU Interruption Arbiter

This block decides which pending interruption request a processor takes, and when it takes it. Requests come from four classes: machine check, program check or supervisor call (one priority level, because the two never arise together), external, and input/output. The external and input/output classes have several request lines each, one per source or channel. The arbiter holds each request in a pending latch. It issues one grant, with an 8-bit interruption code, only when the processor sits between two instructions or idles in the wait state, and only if the state and mask bits allow that class.

A grant starts a status-word swap. While a swap is in progress the block holds instruction execution back, and the grant stays in place until the swap logic reports completion. If further eligible requests remain, the next grant follows on that completion. Execution resumes after the last swap. A machine-check grant is different. After its swap, a lock holds back every other grant until the machine-check handler reports that it has finished. The block does not perform the swap itself, and it does not sequence the diagnostics.

Top module: `irq_arbiter`

## Requirements
- R1: While the processor is running, a first grant is issued only in the cycle after an `insn_boundary` strobe. A request with no strobe produces no grant.
- R2: Grant priority, highest first, is machine check, then program/supervisor call, then external, then input/output. Within the external or the input/output class, the lowest-numbered line wins. `grant_cls` encodes machine check as 0, program/supervisor call as 1, external as 2 and input/output as 3.
- R3: A program/supervisor-call grant carries the 8-bit `prog_code` that was present when the request was accepted. A machine-check grant carries code 0.
- R4: An external grant carries the source line number as its code, and an input/output grant carries the channel number.
- R5: An external or input/output request that arrives while its mask enable is low stays pending. It is granted at a later opportunity once the enable returns high.
- R6: A machine-check or program request that arrives while its enable is low is discarded. A pending request of either class is also discarded when its enable goes low before the grant.
- R7: While `stopped` is high, no grant is issued and no request of any class is latched.
- R8: While `waiting` is high, pending requests are granted without any boundary strobe. A request latched in one cycle is granted in the next.
- R9: `grant_valid` is a one-cycle pulse. `hold_exec` rises with each grant and stays high until `swap_done`. A `swap_done` with further eligible requests pending issues the next grant in that same cycle. A `swap_done` with nothing pending releases `hold_exec`.
- R10: After the swap for a machine-check grant completes, `mchk_lock` is high and no grant is issued until `mchk_done`.
- R11: A granted request's pending latch clears with its grant, so the request is granted exactly once.
- R12: After reset, `grant_valid`, `hold_exec` and `mchk_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stopped | input | 1 | Processor in the manually stopped state |
| waiting | input | 1 | Processor in the wait state |
| insn_boundary | input | 1 | Strobe: an instruction has just completed |
| mchk_en | input | 1 | Machine-check enable (mask bit) |
| prog_en | input | 1 | Program-check enable (mask bit) |
| ext_en | input | 1 | External-class enable (mask bit) |
| io_en | input | 1 | Input/output-class enable (mask bit) |
| mchk_req | input | 1 | Machine-check request |
| prog_req | input | 1 | Program-check or supervisor-call request |
| prog_code | input | 8 | Code accompanying a program/supervisor-call request |
| ext_req | input | EXT_N | External request lines, one per source |
| io_req | input | IO_N | Input/output request lines, one per channel |
| swap_done | input | 1 | Status-word swap for the current grant finished |
| mchk_done | input | 1 | Machine-check handler finished |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_cls | output | 2 | Class of the grant |
| grant_code | output | 8 | Interruption code of the grant |
| hold_exec | output | 1 | Instruction execution held for a swap |
| mchk_lock | output | 1 | Machine-check processing blocks all grants |

## Verification
A sequencer stuck in the swap state shows at the ports as `hold_exec` staying high after a `swap_done` that had nothing left to grant. A sequencer stuck in the run state shows as `hold_exec` staying low in the same cycle as a grant. Both appear one cycle after the triggering input. A pending latch that fails to clear shows as a second grant with the same class and code at the next boundary. A latch that sets when it should not shows as a grant under a mask or a stop. A priority mistake shows in `grant_cls` on the first grant after the boundary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    CLS_MCHK = 2'd0,
    CLS_PROG = 2'd1,
    CLS_EXT  = 2'd2,
    CLS_IO   = 2'd3
  } irq_cls_e;

  typedef enum logic [1:0] {
    SQ_RUN   = 2'd0,
    SQ_SWAP  = 2'd1,
    SQ_MLOCK = 2'd2
  } seq_st_e;
endpackage

// File: rtl/irq_pend_bank.sv
// Pending latches for one request class. DROP_MASKED selects whether a
// low enable discards requests (1) or merely leaves them waiting (0).
module irq_pend_bank #(
  parameter int N           = 1,
  parameter bit DROP_MASKED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         accept,
  input  logic         enable,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] keep;
  logic         admit;

  generate
    if (DROP_MASKED) begin : g_drop
      assign keep  = {N{enable}};
      assign admit = accept & enable;
    end else begin : g_hold
      assign keep  = {N{1'b1}};
      assign admit = accept;
    end
  endgenerate

  always_comb begin
    pend_d = (pend_q & ~clr & keep) | (req & {N{admit}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_pick.sv
// Lowest-index-first selector over a request vector.
module irq_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any    = |req;
  assign onehot = req & ~(req - N'(1));
endmodule

// File: rtl/irq_seq.sv
// Grant sequencer: decides when a grant may issue and which class wins.
module irq_seq
  import irq_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stopped,
  input  logic     waiting,
  input  logic     insn_boundary,
  input  logic     swap_done,
  input  logic     mchk_done,
  input  logic     elig_mchk,
  input  logic     elig_prog,
  input  logic     elig_ext,
  input  logic     elig_io,
  output logic     do_grant,
  output irq_cls_e win_cls,
  output seq_st_e  state
);
  seq_st_e st_q, st_d;
  logic    last_mchk_q, last_mchk_d;
  logic    any_elig;
  logic    open_run;
  logic    open_chain;

  always_comb begin
    if (elig_mchk)      win_cls = CLS_MCHK;
    else if (elig_prog) win_cls = CLS_PROG;
    else if (elig_ext)  win_cls = CLS_EXT;
    else                win_cls = CLS_IO;
  end

  assign any_elig   = elig_mchk | elig_prog | elig_ext | elig_io;
  assign open_run   = (st_q == SQ_RUN) & (insn_boundary | waiting);
  assign open_chain = (st_q == SQ_SWAP) & swap_done & ~last_mchk_q;
  assign do_grant   = any_elig & ~stopped & (open_run | open_chain);

  always_comb begin
    st_d        = st_q;
    last_mchk_d = last_mchk_q;
    if (do_grant) last_mchk_d = (win_cls == CLS_MCHK);
    unique case (st_q)
      SQ_RUN: begin
        if (do_grant) st_d = SQ_SWAP;
      end
      SQ_SWAP: begin
        if (swap_done) begin
          if (last_mchk_q)   st_d = SQ_MLOCK;
          else if (do_grant) st_d = SQ_SWAP;
          else               st_d = SQ_RUN;
        end
      end
      SQ_MLOCK: begin
        if (mchk_done) st_d = SQ_RUN;
      end
      default: st_d = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SQ_RUN;
      last_mchk_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      last_mchk_q <= last_mchk_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int EXT_N = 4,
  parameter int IO_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stopped,
  input  logic              waiting,
  input  logic              insn_boundary,
  input  logic              mchk_en,
  input  logic              prog_en,
  input  logic              ext_en,
  input  logic              io_en,
  input  logic              mchk_req,
  input  logic              prog_req,
  input  logic [CODE_W-1:0] prog_code,
  input  logic [EXT_N-1:0]  ext_req,
  input  logic [IO_N-1:0]   io_req,
  input  logic              swap_done,
  input  logic              mchk_done,
  output logic              grant_valid,
  output logic [1:0]        grant_cls,
  output logic [CODE_W-1:0] grant_code,
  output logic              hold_exec,
  output logic              mchk_lock
);
  localparam int EXT_IW = (EXT_N > 1) ? $clog2(EXT_N) : 1;
  localparam int IO_IW  = (IO_N > 1) ? $clog2(IO_N) : 1;

  logic              accept;
  logic              mchk_pend, prog_pend;
  logic [EXT_N-1:0]  ext_pend, ext_elig, ext_oh, ext_clr;
  logic [IO_N-1:0]   io_pend, io_elig, io_oh, io_clr;
  logic              ext_any, io_any;
  logic [EXT_IW-1:0] ext_idx;
  logic [IO_IW-1:0]  io_idx;
  logic              do_grant;
  irq_cls_e          win_cls;
  seq_st_e           state;
  logic              clr_mchk, clr_prog;
  logic [CODE_W-1:0] pcode_q, pcode_d;
  logic              pcode_ld;
  logic [CODE_W-1:0] code_d;
  logic              gv_q;
  logic [1:0]        gcls_q;
  logic [CODE_W-1:0] gcode_q;

  assign accept = ~stopped;

  irq_pend_bank #(.N(1), .DROP_MASKED(1'b1)) u_mchk (
    .clk(clk), .rst_n(rst_n), .req(mchk_req), .accept(accept),
    .enable(mchk_en), .clr(clr_mchk), .pend(mchk_pend)
  );

  irq_pend_bank #(.N(1), .DROP_MASKED(1'b1)) u_prog (
    .clk(clk), .rst_n(rst_n), .req(prog_req), .accept(accept),
    .enable(prog_en), .clr(clr_prog), .pend(prog_pend)
  );

  irq_pend_bank #(.N(EXT_N), .DROP_MASKED(1'b0)) u_ext (
    .clk(clk), .rst_n(rst_n), .req(ext_req), .accept(accept),
    .enable(ext_en), .clr(ext_clr), .pend(ext_pend)
  );

  irq_pend_bank #(.N(IO_N), .DROP_MASKED(1'b0)) u_io (
    .clk(clk), .rst_n(rst_n), .req(io_req), .accept(accept),
    .enable(io_en), .clr(io_clr), .pend(io_pend)
  );

  assign ext_elig = ext_pend & {EXT_N{ext_en}};
  assign io_elig  = io_pend & {IO_N{io_en}};

  irq_pick #(.N(EXT_N)) u_ext_pick (
    .req(ext_elig), .any(ext_any), .idx(ext_idx), .onehot(ext_oh)
  );

  irq_pick #(.N(IO_N)) u_io_pick (
    .req(io_elig), .any(io_any), .idx(io_idx), .onehot(io_oh)
  );

  irq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .stopped(stopped), .waiting(waiting),
    .insn_boundary(insn_boundary), .swap_done(swap_done),
    .mchk_done(mchk_done), .elig_mchk(mchk_pend), .elig_prog(prog_pend),
    .elig_ext(ext_any), .elig_io(io_any), .do_grant(do_grant),
    .win_cls(win_cls), .state(state)
  );

  // Clear strobes for the winning class only.
  assign clr_mchk = do_grant & (win_cls == CLS_MCHK);
  assign clr_prog = do_grant & (win_cls == CLS_PROG);
  assign ext_clr  = ext_oh & {EXT_N{do_grant & (win_cls == CLS_EXT)}};
  assign io_clr   = io_oh & {IO_N{do_grant & (win_cls == CLS_IO)}};

  // Program/supervisor-call code captured when its request is admitted.
  assign pcode_ld = prog_req & accept & prog_en;
  assign pcode_d  = pcode_ld ? prog_code : pcode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcode_q <= '0;
    else        pcode_q <= pcode_d;
  end

  always_comb begin
    unique case (win_cls)
      CLS_MCHK: code_d = '0;
      CLS_PROG: code_d = pcode_q;
      CLS_EXT:  code_d = CODE_W'(ext_idx);
      default:  code_d = CODE_W'(io_idx);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q    <= 1'b0;
      gcls_q  <= 2'd0;
      gcode_q <= '0;
    end else begin
      gv_q <= do_grant;
      if (do_grant) begin
        gcls_q  <= win_cls;
        gcode_q <= code_d;
      end
    end
  end

  assign grant_valid = gv_q;
  assign grant_cls   = gcls_q;
  assign grant_code  = gcode_q;
  assign hold_exec   = (state == SQ_SWAP);
  assign mchk_lock   = (state == SQ_MLOCK);
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stopped,
  input logic       waiting,
  input logic       insn_boundary,
  input logic       swap_done,
  input logic       grant_valid,
  input logic [1:0] grant_cls,
  input logic       hold_exec,
  input logic       mchk_lock,
  input logic       mchk_pend
);
  // R1 / R8 / R9: a grant needs a boundary, the wait state or a finished swap
  a_r1_grant_window: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $past(insn_boundary | waiting | swap_done));

  // R7: nothing is granted out of the stopped state
  a_r7_no_grant_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !$past(stopped));

  // R9: every grant comes with execution held
  a_r9_hold_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> hold_exec);

  // R9: a grant pulse lasts one cycle unless a swap completes
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !swap_done) |=> !grant_valid);

  // R10: no grant while the machine-check lock is held
  a_r10_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_lock |-> !grant_valid && !hold_exec);

  // R2: a lower class is never granted over a pending machine check
  a_r2_mchk_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_cls != 2'd0) |-> !$past(mchk_pend));
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stopped(stopped), .waiting(waiting),
  .insn_boundary(insn_boundary), .swap_done(swap_done),
  .grant_valid(grant_valid), .grant_cls(grant_cls), .hold_exec(hold_exec),
  .mchk_lock(mchk_lock), .mchk_pend(mchk_pend)
);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       stopped, waiting, insn_boundary;
  logic       mchk_en, prog_en, ext_en, io_en;
  logic       mchk_req, prog_req;
  logic [7:0] prog_code;
  logic [3:0] ext_req;
  logic [7:0] io_req;
  logic       swap_done, mchk_done;
  logic       grant_valid;
  logic [1:0] grant_cls;
  logic [7:0] grant_code;
  logic       hold_exec, mchk_lock;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .stopped(stopped), .waiting(waiting),
    .insn_boundary(insn_boundary), .mchk_en(mchk_en), .prog_en(prog_en),
    .ext_en(ext_en), .io_en(io_en), .mchk_req(mchk_req),
    .prog_req(prog_req), .prog_code(prog_code), .ext_req(ext_req),
    .io_req(io_req), .swap_done(swap_done), .mchk_done(mchk_done),
    .grant_valid(grant_valid), .grant_cls(grant_cls),
    .grant_code(grant_code), .hold_exec(hold_exec), .mchk_lock(mchk_lock)
  );

  // {mchk, prog, pcode[8], ext[4], io[8], exp_cls[2], exp_code[8]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 4'h0, 8'h10, 2'd3, 8'd4},
    {1'b0, 1'b0, 8'h00, 4'h6, 8'h01, 2'd2, 8'd1},
    {1'b0, 1'b1, 8'h5A, 4'h1, 8'h00, 2'd1, 8'h5A},
    {1'b1, 1'b1, 8'h33, 4'h0, 8'h02, 2'd0, 8'h00},
    {1'b0, 1'b0, 8'h00, 4'h0, 8'h80, 2'd3, 8'd7},
    {1'b0, 1'b0, 8'h00, 4'h8, 8'h00, 2'd2, 8'd3}
  };

  task automatic check(input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic boundary();
    insn_boundary = 1'b1; tick(); insn_boundary = 1'b0;
  endtask

  task automatic swap();
    swap_done = 1'b1; tick(); swap_done = 1'b0;
  endtask

  task automatic mdone();
    mchk_done = 1'b1; tick(); mchk_done = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 12; k++) begin
      if (hold_exec)      swap();
      else if (mchk_lock) mdone();
      else                boundary();
    end
  endtask

  task automatic expect_grant(input string rq, input logic [1:0] cls,
                              input logic [7:0] code);
    check(rq, {31'd0, grant_valid}, 32'd1);
    check(rq, {30'd0, grant_cls}, {30'd0, cls});
    check(rq, {24'd0, grant_code}, {24'd0, code});
  endtask

  initial begin
    rst_n = 1'b0; stopped = 1'b0; waiting = 1'b0; insn_boundary = 1'b0;
    mchk_en = 1'b1; prog_en = 1'b1; ext_en = 1'b1; io_en = 1'b1;
    mchk_req = 1'b0; prog_req = 1'b0; prog_code = 8'h00;
    ext_req = '0; io_req = '0; swap_done = 1'b0; mchk_done = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R12 reset state
    check("R12 grant_valid", {31'd0, grant_valid}, 32'd0);
    check("R12 hold_exec", {31'd0, hold_exec}, 32'd0);
    check("R12 mchk_lock", {31'd0, mchk_lock}, 32'd0);

    // Table walk: R2 R3 R4 first-grant priority and codes
    for (int v = 0; v < NV; v++) begin
      mchk_req = VEC[v][31]; prog_req = VEC[v][30];
      prog_code = VEC[v][29:22]; ext_req = VEC[v][21:18];
      io_req = VEC[v][17:10];
      tick();
      mchk_req = 1'b0; prog_req = 1'b0; ext_req = '0; io_req = '0;
      boundary();
      expect_grant($sformatf("R2/R3/R4 vec%0d", v), VEC[v][9:8], VEC[v][7:0]);
      drain();
    end

    // R1: no strobe, no grant
    io_req = 8'h04; tick(); io_req = '0;
    tick(); tick(); tick();
    check("R1 no grant without boundary", {31'd0, grant_valid}, 32'd0);
    check("R1 no hold without boundary", {31'd0, hold_exec}, 32'd0);
    boundary();
    expect_grant("R1 grant after boundary", 2'd3, 8'd2);
    drain();

    // R9 / R11: chained grants, one per swap
    ext_req = 4'h1; io_req = 8'h04; tick(); ext_req = '0; io_req = '0;
    boundary();
    expect_grant("R9 first of chain", 2'd2, 8'd0);
    check("R9 hold with grant", {31'd0, hold_exec}, 32'd1);
    tick();
    check("R9 grant is one pulse", {31'd0, grant_valid}, 32'd0);
    check("R9 hold until swap", {31'd0, hold_exec}, 32'd1);
    swap();
    expect_grant("R9 chained grant", 2'd3, 8'd2);
    check("R9 hold kept in chain", {31'd0, hold_exec}, 32'd1);
    swap();
    check("R9 no grant when empty", {31'd0, grant_valid}, 32'd0);
    check("R9 hold released", {31'd0, hold_exec}, 32'd0);
    boundary();
    check("R11 no repeat grant", {31'd0, grant_valid}, 32'd0);

    // R10: machine-check lock
    mchk_req = 1'b1; io_req = 8'h01; tick(); mchk_req = 1'b0; io_req = '0;
    boundary();
    expect_grant("R10 mchk granted", 2'd0, 8'd0);
    swap();
    check("R10 no grant after mchk swap", {31'd0, grant_valid}, 32'd0);
    check("R10 lock set", {31'd0, mchk_lock}, 32'd1);
    check("R10 hold released", {31'd0, hold_exec}, 32'd0);
    boundary();
    check("R10 boundary blocked by lock", {31'd0, grant_valid}, 32'd0);
    mdone();
    check("R10 lock cleared", {31'd0, mchk_lock}, 32'd0);
    boundary();
    expect_grant("R10 io after lock", 2'd3, 8'd0);
    drain();

    // R5: masked external stays pending
    ext_en = 1'b0;
    ext_req = 4'h4; tick(); ext_req = '0;
    boundary();
    check("R5 masked ext not granted", {31'd0, grant_valid}, 32'd0);
    ext_en = 1'b1;
    boundary();
    expect_grant("R5 ext granted after unmask", 2'd2, 8'd2);
    drain();

    // R6: masked program and machine check dropped
    prog_en = 1'b0; mchk_en = 1'b0;
    prog_req = 1'b1; prog_code = 8'h77; mchk_req = 1'b1; tick();
    prog_req = 1'b0; mchk_req = 1'b0;
    prog_en = 1'b1; mchk_en = 1'b1;
    boundary();
    check("R6 masked arrivals dropped", {31'd0, grant_valid}, 32'd0);
    prog_req = 1'b1; prog_code = 8'h21; tick(); prog_req = 1'b0;
    prog_en = 1'b0; tick(); prog_en = 1'b1;
    boundary();
    check("R6 pending prog dropped by mask", {31'd0, grant_valid}, 32'd0);
    drain();

    // R7: stopped state
    stopped = 1'b1;
    io_req = 8'h02; tick(); io_req = '0;
    boundary();
    check("R7 no grant while stopped", {31'd0, grant_valid}, 32'd0);
    stopped = 1'b0;
    boundary();
    check("R7 request not latched", {31'd0, grant_valid}, 32'd0);

    // R8: wait state grants without boundary
    waiting = 1'b1;
    io_req = 8'h08; tick(); io_req = '0;
    check("R8 not granted in latch cycle", {31'd0, grant_valid}, 32'd0);
    tick();
    expect_grant("R8 wait-state grant", 2'd3, 8'd3);
    waiting = 1'b0;
    drain();

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule